// File: doc/BRIEF.md
# Rotating Execution Unit with Bit Operations

This block is the combinational datapath core of a small 16-bit processor. It takes a decoded 4-bit major opcode, a 4-bit count field, a 3-bit register selector with the low bits of that register, a memory-side operand word, a register word and the incoming flags. In the same cycle it returns the result word, the updated flags, a write-enable for the result, and a branch decision for the bit-test branches.

The arithmetic and logic opcodes can rotate their memory-side operand left by the count field before use. The bit set, bit clear and rotate opcodes take their count either from the instruction's count field or, when the register selector is nonzero, from the low bits of the selected register. A single adder serves add, subtract, compare and quick add. Operand fetch, the register file and stack handling sit outside this block.

Top module: `rml_exec_unit`

## Requirements
- R1: Opcode 0 (add with carry) returns reg + op + C, where op is the memory word after any pre-rotate. It sets C to the carry out, V to signed overflow, and Z and N from the result, and raises the write-enable. Flag vector bits are: bit 0 C, bit 1 Z, bit 2 N, bit 3 interrupt-disable, bit 4 V.
- R2: Opcode 1 (subtract with carry) returns reg - op - (1 - C). C ends as 1 when no borrow occurred. V flags signed overflow, and Z and N follow the result. The write-enable is raised.
- R3: Opcode 5 (compare) returns reg - op with no borrow in and sets C, Z, N and V as subtraction does. The write-enable stays low.
- R4: Opcodes 2, 3, 4 and 6 (AND, XOR, OR with reg, and load of op) update only Z and N. C and V keep their input values. The write-enable is raised.
- R5: For opcodes 0 to 6, a nonzero count field rotates the memory word left by that many bits before the operation. A count of 0 leaves it unrotated.
- R6: Opcode 7 (store) returns the register word unchanged, leaves all flags at their input values and raises the write-enable. The count field has no effect.
- R7: Opcode 8 sets bit n of the memory word and opcode 9 clears it. Both update Z and N from the result, hold C and V, and raise the write-enable.
- R8: For opcodes 8 to 11, n is the 4-bit register low field when the register selector is nonzero, and the count field otherwise.
- R9: Opcode 10 rotates the memory word left by n (0 to 15) and updates Z and N. C and V are held.
- R10: Opcode 11 rotates the 17-bit value {C, word} left by n, where n = 0 means 16. The new C is the top bit of the rotated value, and Z and N follow the 16-bit result.
- R11: Opcode 12 (quick add) returns the memory word plus the count field (0 to 15) and sets C, Z, N and V as addition does. The write-enable is raised.
- R12: Opcode 13 asserts branch-taken when bit (count field) of the register word is 1, and opcode 14 when it is 0. Neither writes nor changes flags, and both return the memory word. Branch-taken is low for every other opcode.
- R13: The interrupt-disable flag always passes through unchanged. Opcode 15 returns the memory word, keeps all flags, and asserts neither write-enable nor branch-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Major opcode |
| cnt_i | input | 4 | Count field of the instruction |
| rsel_i | input | 3 | Register selector; nonzero picks the register count |
| rlow_i | input | 4 | Low bits of the selected register |
| mem_i | input | 16 | Memory-side operand word |
| reg_i | input | 16 | Register operand word |
| flags_i | input | 5 | Incoming flags {V, I, N, Z, C} |
| result_o | output | 16 | Result word |
| flags_o | output | 5 | Updated flags {V, I, N, Z, C} |
| wr_o | output | 1 | Result should be written back |
| take_o | output | 1 | Bit-test branch condition met |

## Verification
The block holds no state, so any fault in an internal select or rotate stage shows at the ports in the same evaluation. The usual signs are a result word rotated by the wrong amount, a carry that came from the wrong adder input, or a flag that moved when it should have held. A wrong count source (immediate or register) or a misrouted rotate stage changes the bit pattern of the result for any operand with asymmetric bits, so the vectors use such operands. Flag holds are checked with C and V preset to 1, so that a dropped hold is visible.

// File: rtl/rml_pkg.sv
package rml_pkg;
   typedef enum logic [3:0] {
      OP_ADC  = 4'd0,
      OP_SBC  = 4'd1,
      OP_AND  = 4'd2,
      OP_XOR  = 4'd3,
      OP_OR   = 4'd4,
      OP_CMP  = 4'd5,
      OP_LOAD = 4'd6,
      OP_STOR = 4'd7,
      OP_BSET = 4'd8,
      OP_BCLR = 4'd9,
      OP_ROL  = 4'd10,
      OP_RLC  = 4'd11,
      OP_ADDQ = 4'd12,
      OP_BBS  = 4'd13,
      OP_BBC  = 4'd14,
      OP_SYS  = 4'd15
   } op_e;

   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_I = 3;
   localparam int FL_V = 4;
   localparam int FL_W = 5;
endpackage

// File: rtl/rml_rotator.sv
module rml_rotator #(
   parameter int W  = 16,
   parameter int AW = 4
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [W-1:0] stage [AW+1];

   assign stage[0] = din;

   for (genvar i = 0; i < AW; i++) begin : g_stage
      localparam int SH = (2 ** i) % W;
      logic [W-1:0] rotated;
      assign rotated      = (stage[i] << SH) | (stage[i] >> (W - SH));
      assign stage[i + 1] = amt[i] ? rotated : stage[i];
   end

   assign dout = stage[AW];
endmodule

// File: rtl/rml_adder.sv
module rml_adder #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W:0] full;

   assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign sum  = full[W-1:0];
   assign cout = full[W];
   assign ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/rml_bitdec.sv
module rml_bitdec #(
   parameter int W  = 16,
   parameter int IW = 4
) (
   input  logic [IW-1:0] idx,
   output logic [W-1:0]  mask
);
   for (genvar k = 0; k < W; k++) begin : g_bit
      assign mask[k] = (idx == IW'(k));
   end
endmodule

// File: rtl/rml_exec_unit.sv
module rml_exec_unit
   import rml_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 4,
   parameter int SW = 3
) (
   input  logic [3:0]      op_i,
   input  logic [CW-1:0]   cnt_i,
   input  logic [SW-1:0]   rsel_i,
   input  logic [CW-1:0]   rlow_i,
   input  logic [DW-1:0]   mem_i,
   input  logic [DW-1:0]   reg_i,
   input  logic [FL_W-1:0] flags_i,
   output logic [DW-1:0]   result_o,
   output logic [FL_W-1:0] flags_o,
   output logic            wr_o,
   output logic            take_o
);
   localparam int RW = CW + 1;
   localparam int TW = DW + 1;

   if (DW != (2 ** CW)) begin : g_bad_width
      $error("rml_exec_unit: DW must equal 2**CW");
   end
   if (SW < 1) begin : g_bad_sel
      $error("rml_exec_unit: SW must be at least 1");
   end

   op_e op;
   assign op = op_e'(op_i);

   logic [CW-1:0] n_sel;
   logic          is_alu;
   logic [CW-1:0] rot_amt;
   logic [DW-1:0] opnd;
   logic [RW-1:0] rlc_amt;
   logic [TW-1:0] rlc_out;
   logic [DW-1:0] bmask;

   assign n_sel  = (rsel_i != '0) ? rlow_i : cnt_i;
   assign is_alu = (op_i[3] == 1'b0) && (op != OP_STOR);

   always_comb begin
      if (is_alu)           rot_amt = cnt_i;
      else if (op == OP_ROL) rot_amt = n_sel;
      else                  rot_amt = '0;
   end

   rml_rotator #(.W(DW), .AW(CW)) u_rot16 (
      .din  (mem_i),
      .amt  (rot_amt),
      .dout (opnd)
   );

   assign rlc_amt = (n_sel == '0) ? RW'(DW) : {1'b0, n_sel};

   rml_rotator #(.W(TW), .AW(RW)) u_rot17 (
      .din  ({flags_i[FL_C], mem_i}),
      .amt  (rlc_amt),
      .dout (rlc_out)
   );

   rml_bitdec #(.W(DW), .IW(CW)) u_dec (
      .idx  (n_sel),
      .mask (bmask)
   );

   logic [DW-1:0] add_a, add_b, add_sum;
   logic          add_cin, add_cout, add_ovf;

   always_comb begin
      add_a   = reg_i;
      add_b   = opnd;
      add_cin = 1'b0;
      case (op)
         OP_ADC:  add_cin = flags_i[FL_C];
         OP_SBC: begin
            add_b   = ~opnd;
            add_cin = flags_i[FL_C];
         end
         OP_CMP: begin
            add_b   = ~opnd;
            add_cin = 1'b1;
         end
         OP_ADDQ: begin
            add_a = mem_i;
            add_b = {{(DW-CW){1'b0}}, cnt_i};
         end
         default: ;
      endcase
   end

   rml_adder #(.W(DW)) u_add (
      .a    (add_a),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   logic [DW-1:0] res;
   logic          c_nx, v_nx, upd_zn, wr, take;
   logic          bit_sel;

   assign bit_sel = reg_i[cnt_i];

   always_comb begin
      res    = mem_i;
      c_nx   = flags_i[FL_C];
      v_nx   = flags_i[FL_V];
      upd_zn = 1'b0;
      wr     = 1'b0;
      take   = 1'b0;
      case (op)
         OP_ADC, OP_SBC, OP_CMP, OP_ADDQ: begin
            res    = add_sum;
            c_nx   = add_cout;
            v_nx   = add_ovf;
            upd_zn = 1'b1;
            wr     = (op != OP_CMP);
         end
         OP_AND: begin
            res = reg_i & opnd; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_XOR: begin
            res = reg_i ^ opnd; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_OR: begin
            res = reg_i | opnd; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_LOAD: begin
            res = opnd; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_STOR: begin
            res = reg_i; wr = 1'b1;
         end
         OP_BSET: begin
            res = mem_i | bmask; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_BCLR: begin
            res = mem_i & ~bmask; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_ROL: begin
            res = opnd; upd_zn = 1'b1; wr = 1'b1;
         end
         OP_RLC: begin
            res    = rlc_out[DW-1:0];
            c_nx   = rlc_out[DW];
            upd_zn = 1'b1;
            wr     = 1'b1;
         end
         OP_BBS:  take = bit_sel;
         OP_BBC:  take = ~bit_sel;
         default: ;
      endcase
   end

   always_comb begin
      flags_o        = flags_i;
      flags_o[FL_C]  = c_nx;
      flags_o[FL_V]  = v_nx;
      if (upd_zn) begin
         flags_o[FL_Z] = (res == '0);
         flags_o[FL_N] = res[DW-1];
      end
   end

   assign result_o = res;
   assign wr_o     = wr;
   assign take_o   = take;
endmodule

// File: rtl/rml_exec_unit_chk.sv
module rml_exec_unit_chk
   import rml_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 4,
   parameter int SW = 3
) (
   input logic [3:0]      op_i,
   input logic [CW-1:0]   cnt_i,
   input logic [SW-1:0]   rsel_i,
   input logic [CW-1:0]   rlow_i,
   input logic [DW-1:0]   mem_i,
   input logic [DW-1:0]   reg_i,
   input logic [FL_W-1:0] flags_i,
   input logic [DW-1:0]   result_o,
   input logic [FL_W-1:0] flags_o,
   input logic            wr_o,
   input logic            take_o
);
   logic zn_op;
   assign zn_op = (op_i != 4'd7) && (op_i < 4'd13);

   always_comb begin
      AST_IFLAG_HELD: assert (flags_o[FL_I] == flags_i[FL_I]) else $error("I flag changed"); // R13
      AST_TAKE_BRANCH_ONLY: assert (!take_o || op_i == 4'd13 || op_i == 4'd14) else $error("stray take"); // R12
      AST_CMP_NO_WRITE: assert (op_i != 4'd5 || !wr_o) else $error("compare wrote"); // R3
      AST_STORE_PASS: assert (op_i != 4'd7 || (result_o == reg_i && flags_o == flags_i)) else $error("store altered"); // R6
      AST_LOGIC_CV_HELD: assert (!(op_i inside {4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd9, 4'd10})
                                 || (flags_o[FL_C] == flags_i[FL_C] && flags_o[FL_V] == flags_i[FL_V]))
         else $error("C/V moved"); // R4
      AST_ZERO_TRACKS: assert (!zn_op || flags_o[FL_Z] == (result_o == '0)) else $error("Z mismatch"); // R1
      AST_BSET_ONE_BIT: assert (op_i != 4'd8 || ($countones(result_o & ~mem_i) <= 1 && (result_o & mem_i) == mem_i))
         else $error("bitset changed other bits"); // R7
      AST_REG_COUNT: assert (!(op_i == 4'd8 && rsel_i != '0) || result_o[rlow_i]) else $error("reg count ignored"); // R8
      AST_BBS_COND: assert (op_i != 4'd13 || take_o == reg_i[cnt_i]) else $error("bbs cond"); // R12
      AST_BRANCH_NO_WRITE: assert (!(op_i inside {4'd13, 4'd14, 4'd15}) || !wr_o) else $error("branch wrote"); // R13
   end
endmodule

bind rml_exec_unit rml_exec_unit_chk #(.DW(DW), .CW(CW), .SW(SW)) u_chk (.*);

// File: tb/tb_rml_exec_unit.sv
module tb_rml_exec_unit;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [3:0]  op_i, cnt_i, rlow_i;
   logic [2:0]  rsel_i;
   logic [15:0] mem_i, reg_i, result_o;
   logic [4:0]  flags_i, flags_o;
   logic        wr_o, take_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   rml_exec_unit dut (
      .op_i(op_i), .cnt_i(cnt_i), .rsel_i(rsel_i), .rlow_i(rlow_i),
      .mem_i(mem_i), .reg_i(reg_i), .flags_i(flags_i),
      .result_o(result_o), .flags_o(flags_o), .wr_o(wr_o), .take_o(take_o)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [3:0]  cnt;
      logic [2:0]  rsel;
      logic [3:0]  rlow;
      logic [15:0] mem;
      logic [15:0] rg;
      logic [4:0]  fin;
      logic [15:0] res;
      logic [4:0]  fout;
      logic        wr;
      logic        tk;
      logic [3:0]  req;
   } vec_t;

   // flags {V,I,N,Z,C}
   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      '{4'd0, 4'd0, 3'd0, 4'd0, 16'h0001, 16'h7FFF, 5'b00000, 16'h8000, 5'b10100, 1'b1, 1'b0, 4'd1},  // R1
      '{4'd0, 4'd0, 3'd0, 4'd0, 16'hFFFF, 16'h0001, 5'b01001, 16'h0001, 5'b01001, 1'b1, 1'b0, 4'd1},  // R1
      '{4'd1, 4'd0, 3'd0, 4'd0, 16'h0003, 16'h0005, 5'b00001, 16'h0002, 5'b00001, 1'b1, 1'b0, 4'd2},  // R2
      '{4'd1, 4'd0, 3'd0, 4'd0, 16'h0005, 16'h0003, 5'b00000, 16'hFFFD, 5'b00100, 1'b1, 1'b0, 4'd2},  // R2
      '{4'd1, 4'd0, 3'd0, 4'd0, 16'h0001, 16'h8000, 5'b00001, 16'h7FFF, 5'b10001, 1'b1, 1'b0, 4'd2},  // R2
      '{4'd5, 4'd0, 3'd0, 4'd0, 16'h1234, 16'h1234, 5'b00000, 16'h0000, 5'b00011, 1'b0, 1'b0, 4'd3},  // R3
      '{4'd5, 4'd0, 3'd0, 4'd0, 16'h0002, 16'h0001, 5'b00001, 16'hFFFF, 5'b00100, 1'b0, 1'b0, 4'd3},  // R3
      '{4'd6, 4'd4, 3'd0, 4'd0, 16'h1234, 16'h0000, 5'b10001, 16'h2341, 5'b10001, 1'b1, 1'b0, 4'd5},  // R5
      '{4'd2, 4'd8, 3'd0, 4'd0, 16'h00FF, 16'hF0F0, 5'b00000, 16'hF000, 5'b00100, 1'b1, 1'b0, 4'd5},  // R5
      '{4'd1, 4'd1, 3'd0, 4'd0, 16'h8000, 16'h0010, 5'b00001, 16'h000F, 5'b00001, 1'b1, 1'b0, 4'd5},  // R5
      '{4'd3, 4'd0, 3'd0, 4'd0, 16'hAAAA, 16'hAAAA, 5'b10001, 16'h0000, 5'b10011, 1'b1, 1'b0, 4'd4},  // R4
      '{4'd4, 4'd0, 3'd0, 4'd0, 16'h0F00, 16'h00F0, 5'b00000, 16'h0FF0, 5'b00000, 1'b1, 1'b0, 4'd4},  // R4
      '{4'd7, 4'd5, 3'd0, 4'd0, 16'h1111, 16'hBEEF, 5'b10101, 16'hBEEF, 5'b10101, 1'b1, 1'b0, 4'd6},  // R6
      '{4'd8, 4'd15,3'd0, 4'd0, 16'h0001, 16'h0000, 5'b00000, 16'h8001, 5'b00100, 1'b1, 1'b0, 4'd7},  // R7
      '{4'd9, 4'd0, 3'd0, 4'd0, 16'h0001, 16'h0000, 5'b00001, 16'h0000, 5'b00011, 1'b1, 1'b0, 4'd7},  // R7
      '{4'd8, 4'd2, 3'd3, 4'd5, 16'h0000, 16'h0000, 5'b00000, 16'h0020, 5'b00000, 1'b1, 1'b0, 4'd8},  // R8
      '{4'd10,4'd0, 3'd1, 4'd8, 16'h1234, 16'h0000, 5'b00000, 16'h3412, 5'b00000, 1'b1, 1'b0, 4'd8},  // R8
      '{4'd10,4'd4, 3'd0, 4'd0, 16'h8001, 16'h0000, 5'b00001, 16'h0018, 5'b00001, 1'b1, 1'b0, 4'd9},  // R9
      '{4'd10,4'd0, 3'd0, 4'd0, 16'h8000, 16'h0000, 5'b00000, 16'h8000, 5'b00100, 1'b1, 1'b0, 4'd9},  // R9
      '{4'd11,4'd1, 3'd0, 4'd0, 16'h8000, 16'h0000, 5'b00000, 16'h0000, 5'b00011, 1'b1, 1'b0, 4'd10}, // R10
      '{4'd11,4'd0, 3'd0, 4'd0, 16'h0001, 16'h0000, 5'b00001, 16'h8000, 5'b00101, 1'b1, 1'b0, 4'd10}, // R10
      '{4'd12,4'd3, 3'd0, 4'd0, 16'hFFFE, 16'h0000, 5'b00000, 16'h0001, 5'b00001, 1'b1, 1'b0, 4'd11}, // R11
      '{4'd12,4'd1, 3'd0, 4'd0, 16'h7FFF, 16'h0000, 5'b00000, 16'h8000, 5'b10100, 1'b1, 1'b0, 4'd11}, // R11
      '{4'd13,4'd3, 3'd0, 4'd0, 16'h4000, 16'h0008, 5'b00001, 16'h4000, 5'b00001, 1'b0, 1'b1, 4'd12}, // R12
      '{4'd13,4'd2, 3'd0, 4'd0, 16'h4000, 16'h0008, 5'b00001, 16'h4000, 5'b00001, 1'b0, 1'b0, 4'd12}, // R12
      '{4'd14,4'd2, 3'd0, 4'd0, 16'h4000, 16'h0008, 5'b00000, 16'h4000, 5'b00000, 1'b0, 1'b1, 4'd12}, // R12
      '{4'd15,4'd0, 3'd0, 4'd0, 16'h5555, 16'h0000, 5'b01000, 16'h5555, 5'b01000, 1'b0, 1'b0, 4'd13}  // R13
   };

   task automatic apply(input vec_t v);
      @(posedge clk);
      op_i = v.op; cnt_i = v.cnt; rsel_i = v.rsel; rlow_i = v.rlow;
      mem_i = v.mem; reg_i = v.rg; flags_i = v.fin;
      @(negedge clk);
   endtask

   task automatic check_vec(input vec_t v, input int idx);
      checks++;
      if (result_o !== v.res || flags_o !== v.fout || wr_o !== v.wr || take_o !== v.tk) begin
         errors++;
         $display("FAIL R%0d vec %0d: res=%h flags=%b wr=%b take=%b, expected res=%h flags=%b wr=%b take=%b",
                  v.req, idx, result_o, flags_o, wr_o, take_o, v.res, v.fout, v.wr, v.tk);
      end
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected under 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin : stim
      vec_t v;
      logic [15:0] first_res;
      op_i = '0; cnt_i = '0; rsel_i = '0; rlow_i = '0;
      mem_i = '0; reg_i = '0; flags_i = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);

      // Reset state: all-zero inputs give add of zeros, Z set (R1)
      checks++;
      if (result_o !== 16'h0000 || flags_o !== 5'b00010 || wr_o !== 1'b1 || take_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 idle: res=%h flags=%b wr=%b take=%b, expected res=0000 flags=00010 wr=1 take=0",
                  result_o, flags_o, wr_o, take_o);
      end

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check_vec(VEC[i], i);
      end

      // R6: store ignores count field
      v = VEC[12];
      v.cnt = 4'd0;
      apply(v);
      first_res = result_o;
      v.cnt = 4'd11;
      apply(v);
      checks++;
      if (result_o !== first_res || result_o !== 16'hBEEF) begin
         errors++;
         $display("FAIL R6 store count ignored: res=%h expected %h", result_o, 16'hBEEF);
      end

      // R13: interrupt-disable flag passes for every opcode, both polarities
      for (int op = 0; op < 16; op++) begin
         for (int pol = 0; pol < 2; pol++) begin
            v = VEC[0];
            v.op  = op[3:0];
            v.fin = (pol != 0) ? 5'b01000 : 5'b10111;
            apply(v);
            checks++;
            if (flags_o[3] !== v.fin[3]) begin
               errors++;
               $display("FAIL R13 op %0d: I=%b expected %b", op, flags_o[3], v.fin[3]);
            end
            checks++;
            if (op != 13 && op != 14 && take_o !== 1'b0) begin
               errors++;
               $display("FAIL R12 op %0d: take=%b expected 0", op, take_o);
            end
         end
      end

      // R10: rlc via register count 16 (rlow 0, rsel nonzero) rotates right by one
      v = VEC[20];
      v.cnt = 4'd5; v.rsel = 3'd2; v.rlow = 4'd0;
      apply(v);
      checks++;
      if (result_o !== 16'h8000 || flags_o[0] !== 1'b1) begin
         errors++;
         $display("FAIL R10 reg count 16: res=%h C=%b expected res=8000 C=1", result_o, flags_o[0]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule